// File: doc/BRIEF.md
# Parallel ADC Readout Sequencer

This block is a host-side controller for an analog-to-digital converter that delivers its result on a parallel, three-state data bus. It drives the converter's active-low chip-select and its read/convert select line. It starts a conversion, then waits for the converter's active-low end-of-conversion flag to fall. Once the flag has fallen, it issues a fixed number of chip-select strobes with the read/convert line high. On the last of these strobes it holds chip-select low, waits out the converter's output delay, and latches the bus word. A start pulse asks for one conversion. The finished word is held in a register and offered on a valid/ready output.

When the converter is run in its power-down mode, the reference sleeps between conversions. Each request then begins with a wake strobe: chip-select falls with read/convert low. The controller waits a programmable settling time after that strobe before it starts the real conversion. A conversion whose end-of-conversion flag never falls is stopped by a timeout. The timeout reports a one-cycle error pulse and returns the controller to idle with chip-select released.

Top module: `adc_rd_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `rc` is 0, `out_valid` is 0 and `timeout_err` is 0.
- R2: A `start` pulse taken in idle, with no unread result and `shutdown_en` low, produces exactly one `cs_n` falling edge with `rc` = 0 (0 means convert, 1 means read) before any read strobe.
- R3: No `cs_n` falling edge with `rc` = 1 occurs while the converter's end-of-conversion flag `eoc_n` is still high after a conversion start.
- R4: After the end-of-conversion flag falls, exactly READ_EDGE (default 3) `cs_n` falling edges occur with `rc` = 1, and `cs_n` stays low after the last one.
- R5: The bus is sampled only after `cs_n` has been low for TDO_CYC + 1 cycles following the final read strobe. `cs_n` returns high in the same cycle that `out_valid` rises.
- R6: A captured word is shown on `out_data` with `out_valid` = 1. The word stays stable until `out_ready` is seen, and `out_valid` clears in the cycle after `out_valid && out_ready`.
- R7: While `out_valid` is 1, `start` is ignored: `cs_n` stays high and no conversion begins.
- R8: With `shutdown_en` = 1, each request first gives a wake strobe (a `cs_n` fall with `rc` = 0). The conversion strobe follows at least WAKE_CYC cycles later.
- R9: If `eoc_n` does not fall within TIMEOUT_CYC cycles of the conversion strobe's release, `timeout_err` pulses for one cycle with `cs_n` high, and no result is presented.
- R10: `rc` changes only while `cs_n` is high in both the current and the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion (taken in idle when no result is pending) |
| shutdown_en | input | 1 | Apply wake strobe and settling wait before each conversion |
| cs_n | output | 1 | Converter chip-select, active low |
| rc | output | 1 | Read/convert select: 0 convert, 1 read |
| eoc_n | input | 1 | Converter end-of-conversion flag; falling edge means done |
| adc_data | input | DATA_W | Converter parallel data bus |
| out_valid | output | 1 | Captured word available |
| out_data | output | DATA_W | Captured word |
| out_ready | input | 1 | Consumer accepts the word |
| timeout_err | output | 1 | One-cycle pulse when end-of-conversion never arrived |

## Verification
The bound checker watches the following on every cycle:
- read strobes never come before an end-of-conversion fall,
- `rc` changes only with chip-select idle,
- the held word stays steady under back-pressure,
- chip-select is high whenever a result is pending or a timeout is reported,
- chip-select rises exactly as a capture lands.

The bench's converter model is needed for everything that depends on counting and data:
- how many read strobes occur in each conversion,
- whether the word was taken after the output delay rather than before it (an early sample returns junk),
- the length of the settling gap after a wake,
- the timeout latency,
- that a start during a pending result leaves the bus untouched.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAKE_LO,
    S_WAKE_WAIT,
    S_CONV_LO,
    S_CONV_WAIT,
    S_RD_HI,
    S_RD_LO,
    S_RD_HOLD
  } seq_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_rd_edge.sv
module adc_rd_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/adc_rd_hold.sv
module adc_rd_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (capture) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int READ_EDGE   = 3,
  parameter int PULSE_CYC   = 2,
  parameter int TDO_CYC     = 3,
  parameter int WAKE_CYC    = 1500000,
  parameter int TIMEOUT_CYC = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              shutdown_en,
  output logic              cs_n,
  output logic              rc,
  input  logic              eoc_n,
  input  logic [DATA_W-1:0] adc_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              timeout_err
);
  localparam int MAX_CNT = max4(PULSE_CYC, TDO_CYC, WAKE_CYC, TIMEOUT_CYC);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int EDGE_W  = $clog2(READ_EDGE + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(READ_EDGE - 1);

  seq_state_e        st, st_nx;
  logic              cs_nx, rc_nx, err_nx;
  logic [EDGE_W-1:0] ecnt, ecnt_nx;
  logic              eoc_fall;
  logic              tm_load, tm_done;
  logic [CNT_W-1:0]  tm_val;
  logic              cap;

  adc_rd_edge #(.STAGES(SYNC_STAGES)) u_eoc (
    .clk (clk), .rst (rst), .din (eoc_n), .fall (eoc_fall)
  );

  adc_rd_timer #(.W(CNT_W)) u_tm (
    .clk (clk), .rst (rst), .load (tm_load), .val (tm_val), .done (tm_done)
  );

  adc_rd_hold #(.W(DATA_W)) u_hold (
    .clk (clk), .rst (rst), .capture (cap), .din (adc_data),
    .ready (out_ready), .valid (out_valid), .dout (out_data)
  );

  always_comb begin
    st_nx   = st;
    cs_nx   = cs_n;
    rc_nx   = rc;
    ecnt_nx = ecnt;
    err_nx  = 1'b0;
    tm_load = 1'b0;
    tm_val  = '0;
    cap     = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (rc) begin
          rc_nx = 1'b0;
        end else if (start && !out_valid) begin
          cs_nx   = 1'b0;
          tm_load = 1'b1;
          tm_val  = CNT_W'(PULSE_CYC);
          st_nx   = shutdown_en ? S_WAKE_LO : S_CONV_LO;
        end
      end
      S_WAKE_LO: if (tm_done) begin
        cs_nx   = 1'b1;
        tm_load = 1'b1;
        tm_val  = CNT_W'(WAKE_CYC);
        st_nx   = S_WAKE_WAIT;
      end
      S_WAKE_WAIT: if (tm_done) begin
        cs_nx   = 1'b0;
        tm_load = 1'b1;
        tm_val  = CNT_W'(PULSE_CYC);
        st_nx   = S_CONV_LO;
      end
      S_CONV_LO: if (tm_done) begin
        cs_nx   = 1'b1;
        tm_load = 1'b1;
        tm_val  = CNT_W'(TIMEOUT_CYC);
        st_nx   = S_CONV_WAIT;
      end
      S_CONV_WAIT: begin
        if (eoc_fall) begin
          rc_nx   = 1'b1;
          ecnt_nx = '0;
          tm_load = 1'b1;
          tm_val  = CNT_W'(PULSE_CYC);
          st_nx   = S_RD_HI;
        end else if (tm_done) begin
          err_nx = 1'b1;
          st_nx  = S_IDLE;
        end
      end
      S_RD_HI: if (tm_done) begin
        cs_nx   = 1'b0;
        ecnt_nx = ecnt + 1'b1;
        tm_load = 1'b1;
        if (ecnt == LAST_EDGE) begin
          tm_val = CNT_W'(TDO_CYC);
          st_nx  = S_RD_HOLD;
        end else begin
          tm_val = CNT_W'(PULSE_CYC);
          st_nx  = S_RD_LO;
        end
      end
      S_RD_LO: if (tm_done) begin
        cs_nx   = 1'b1;
        tm_load = 1'b1;
        tm_val  = CNT_W'(PULSE_CYC);
        st_nx   = S_RD_HI;
      end
      S_RD_HOLD: if (tm_done) begin
        cap   = 1'b1;
        cs_nx = 1'b1;
        st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cs_n        <= 1'b1;
      rc          <= 1'b0;
      ecnt        <= '0;
      timeout_err <= 1'b0;
    end else begin
      st          <= st_nx;
      cs_n        <= cs_nx;
      rc          <= rc_nx;
      ecnt        <= ecnt_nx;
      timeout_err <= err_nx;
    end
  end
endmodule

// File: rtl/adc_rd_seq_chk.sv
module adc_rd_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rc,
  input logic              eoc_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              timeout_err
);
  logic cs_q, eoc_q, eoc_seen, cs_fall;

  assign cs_fall = cs_q & ~cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      eoc_q    <= 1'b0;
      eoc_seen <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      eoc_q <= eoc_n;
      if (eoc_q && !eoc_n)      eoc_seen <= 1'b1;
      else if (cs_fall && !rc)  eoc_seen <= 1'b0;
    end
  end

  a_r3_read_after_eoc: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && rc) |-> eoc_seen);

  a_r5_release_on_capture: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (cs_n && !$past(cs_n)));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_clear_on_ready: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !out_valid);

  a_r7_bus_idle_pending: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cs_n);

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> !timeout_err);

  a_r9_err_released: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (cs_n && !out_valid));

  a_r10_rc_setup: assert property (@(posedge clk) disable iff (rst)
    (rc != $past(rc)) |-> (cs_n && $past(cs_n)));
endmodule

bind adc_rd_seq adc_rd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk (clk), .rst (rst), .cs_n (cs_n), .rc (rc), .eoc_n (eoc_n),
  .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
  .timeout_err (timeout_err)
);

// File: tb/adc_rd_seq_test.sv
module adc_rd_seq_test;
  localparam int DW    = 16;
  localparam int NRD   = 3;
  localparam int PULSE = 2;
  localparam int TDO   = 3;
  localparam int WAKE  = 40;
  localparam int TMO   = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, shutdown_en = 1'b0, out_ready = 1'b0;
  logic cs_n, rc, out_valid, timeout_err;
  logic [DW-1:0] adc_data, out_data;
  logic eoc_n = 1'b0;

  always #4 clk = ~clk;

  adc_rd_seq #(.DATA_W(DW), .READ_EDGE(NRD), .PULSE_CYC(PULSE), .TDO_CYC(TDO),
               .WAKE_CYC(WAKE), .TIMEOUT_CYC(TMO)) uut (
    .clk (clk), .rst (rst), .start (start), .shutdown_en (shutdown_en),
    .cs_n (cs_n), .rc (rc), .eoc_n (eoc_n), .adc_data (adc_data),
    .out_valid (out_valid), .out_data (out_data), .out_ready (out_ready),
    .timeout_err (timeout_err)
  );

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] samp(input int k);
    return 16'h5A3C ^ 16'(k * 2327);
  endfunction

  // behavioural converter
  int  cyc = 0, conv_starts = 0, wakes = 0, rd_falls = 0, total_falls = 0;
  int  conv_cyc = 0, wake_cyc = 0, conv_cnt = 0, since = 0, early_rd = 0, rc_viol = 0;
  int  conv_lat = 4;
  bit  hang = 1'b0, sd_mode = 1'b0, asleep = 1'b1, hold = 1'b0;
  logic prev_cs = 1'b1, prev_rc = 1'b0;

  assign adc_data = (hold && since >= TDO) ? samp(conv_starts) : ~samp(conv_starts);

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    prev_cs <= cs_n;
    prev_rc <= rc;
    if (!rst && rc != prev_rc && (!cs_n || !prev_cs)) rc_viol <= rc_viol + 1;
    if (hold) begin
      if (cs_n) hold <= 1'b0;
      else      since <= since + 1;
    end
    if (eoc_n && conv_cnt > 0) begin
      conv_cnt <= conv_cnt - 1;
      if (conv_cnt == 1 && !hang) eoc_n <= 1'b0;
    end
    if (!rst && prev_cs && !cs_n) begin
      total_falls <= total_falls + 1;
      if (!rc) begin
        if (sd_mode && asleep) begin
          asleep   <= 1'b0;
          wakes    <= wakes + 1;
          wake_cyc <= cyc;
        end else begin
          eoc_n       <= 1'b1;
          conv_cnt    <= conv_lat;
          rd_falls    <= 0;
          conv_cyc    <= cyc;
          conv_starts <= conv_starts + 1;
          asleep      <= 1'b1;
        end
      end else begin
        if (eoc_n) early_rd <= early_rd + 1;
        rd_falls <= rd_falls + 1;
        if (rd_falls == NRD - 1) begin
          hold  <= 1'b1;
          since <= 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_conv(input bit sd, input int lat, input bit hg, input int rdly);
    int n, s0, w0, f0;
    logic [DW-1:0] held;
    @(negedge clk);
    shutdown_en = sd; sd_mode = sd; conv_lat = lat; hang = hg;
    s0 = conv_starts; w0 = wakes;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!out_valid && !timeout_err && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(n < 3000, "R2 completion", n, 3000);
    check(conv_starts == s0 + 1, "R2 single conversion start", conv_starts - s0, 1);
    if (sd) check(wakes == w0 + 1, "R8 wake strobe", wakes - w0, 1);
    else    check(wakes == w0, "R2 no wake strobe", wakes - w0, 0);
    if (sd) check(conv_cyc - wake_cyc >= WAKE, "R8 settling gap", conv_cyc - wake_cyc, WAKE);
    if (hg) begin
      check(timeout_err == 1'b1, "R9 timeout raised", timeout_err, 1);
      check(cs_n == 1'b1, "R9 cs released", cs_n, 1);
      check(!out_valid, "R9 no result", out_valid, 0);
      check(cyc - conv_cyc >= TMO && cyc - conv_cyc <= TMO + PULSE + 10,
            "R9 timeout latency", cyc - conv_cyc, TMO);
      @(negedge clk);
      check(!timeout_err, "R9 one-cycle pulse", timeout_err, 0);
      repeat (3) @(negedge clk);
      return;
    end
    check(out_data == samp(conv_starts), "R5 captured word", out_data, samp(conv_starts));
    check(rd_falls == NRD, "R4 read strobe count", rd_falls, NRD);
    check(cs_n == 1'b1, "R5 cs high at capture", cs_n, 1);
    check(early_rd == 0, "R3 no early read", early_rd, 0);
    check(rc_viol == 0, "R10 rc only while cs high", rc_viol, 0);
    held = out_data;
    f0 = total_falls;
    start = 1'b1;
    repeat (rdly + 2) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(out_valid && out_data == held, "R6 hold under back-pressure", out_data, held);
    check(total_falls == f0 && cs_n, "R7 start ignored while pending", total_falls - f0, 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid, "R6 cleared after ready", out_valid, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    check(rc == 1'b0, "R1 reset rc", rc, 0);
    check(!out_valid, "R1 reset out_valid", out_valid, 0);
    check(!timeout_err, "R1 reset timeout_err", timeout_err, 0);
    for (int sd = 0; sd < 2; sd++) begin
      for (int lat = 1; lat <= 30; lat += 3) run_conv(sd[0], lat, 1'b0, lat % 4);
    end
    run_conv(1'b0, 5, 1'b1, 0);
    run_conv(1'b0, 5, 1'b0, 1);
    run_conv(1'b1, 5, 1'b1, 0);
    run_conv(1'b1, 9, 1'b0, 2);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule